// File: doc/BRIEF.md
# Page-Crossing Linear Access Splitter

This block sits between a load/store front end and the physical memory system. It accepts a linear access of one to four bytes at any byte alignment and cuts it into chunks that stay inside one 4 KB page. Each chunk gets its own address translation. The chunk's memory traffic follows only after that translation has returned. The result is a sequence of byte, halfword and word accesses to physical memory.

For a read, the returned bytes are gathered into one little-endian 32-bit result, lowest linear byte in bits 7:0. For a write, the write data is used up from its low byte upward in the same order. A chunk of three bytes is issued as a byte access followed by a halfword access at the next physical address.

A translation fault on any chunk stops the operation and is reported upward with the linear address of the failing chunk. Bytes already written by earlier chunks stay written. A request whose length is zero or larger than four is refused at once.

Top module: `lin_split`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1 and `rsp_valid`, `xl_req_valid` and `mem_req_valid` are 0.
- R2: A request with `req_len` of 0 or greater than 4 is answered in the very next cycle with `rsp_status` = 1 (bad length). It makes no translation request and no memory request.
- R3: The first chunk is min(`req_len`, 0x1000 minus the low 12 bits of `req_addr`) bytes long. Any remainder forms a second chunk starting at the next page. Each chunk issues exactly one translation request, carrying the linear address of the chunk's first byte, and that request comes before any memory request for the chunk. No memory access spans a page. A successful operation ends with `rsp_status` = 0.
- R4: `mem_req_size` encodes 0 = byte, 1 = halfword, 2 = word. A 1-, 2- or 4-byte chunk is one access of that size at the translated address. A 3-byte chunk is a byte access at the translated address followed by a halfword access at that address plus 1.
- R5: Memory read data arrives right-justified in `mem_rsp_rdata`; only the low bytes of the access size are used. `rsp_rdata` holds the bytes in linear order, with linear byte i in bits 8i+7:8i.
- R6: Write data leaves right-justified in `mem_req_wdata`. Linear byte i of the access receives bits 8i+7:8i of `req_wdata`.
- R7: A fault on a chunk's translation ends the operation with `rsp_status` = 2. `rsp_fault_addr` holds the linear address of that chunk. No further memory access follows, and writes done by earlier chunks remain.
- R8: A memory request is held with a stable address and size until `mem_req_ready`. `req_ready` is 0 from acceptance until the response. `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Linear byte address |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 bad length, 2 translation fault |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_fault_addr | output | ADDR_W | Linear address of faulting chunk |
| xl_req_valid | output | 1 | Translation request |
| xl_req_ready | input | 1 | Translator accepts request |
| xl_req_addr | output | ADDR_W | Linear address to translate |
| xl_req_write | output | 1 | Access kind for permission checking |
| xl_rsp_valid | input | 1 | Translation result present |
| xl_rsp_paddr | input | ADDR_W | Physical address of chunk start |
| xl_rsp_fault | input | 1 | Translation refused |
| mem_req_valid | output | 1 | Physical memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write |
| mem_req_addr | output | ADDR_W | Physical byte address |
| mem_req_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_req_wdata | output | 32 | Right-justified write data |
| mem_rsp_valid | input | 1 | Memory completion |
| mem_rsp_rdata | input | 32 | Right-justified read data |

## Verification
The bench sweeps every length from 1 to 4 at every offset within eight bytes of a page end and at the first offsets of a page, for both reads and writes. It checks each translation address, each piece's size and address, and every byte moved. A design that measured the page budget off by one would split an access ending exactly on the boundary, or fail to split one that crosses it. A design that mishandled the 3-byte chunk would issue a misaligned halfword first, or reuse the old physical address for the second piece. Garbage in the unused upper bytes of the memory read data exposes a missing size mask. Faults on the first and on the second chunk check that the operation stops, that the reported address is the chunk's own, and that bytes already written are kept.

// File: rtl/lin_split_pkg.sv
package lin_split_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XREQ,
        ST_XWAIT,
        ST_MREQ,
        ST_MWAIT,
        ST_RESP
    } split_state_e;

    typedef enum logic [1:0] {
        RSP_OK     = 2'd0,
        RSP_BADLEN = 2'd1,
        RSP_FAULT  = 2'd2
    } rsp_status_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic [2:0] chunk_len;    // bytes in the chunk about to start
        logic [2:0] piece_bytes;  // bytes in the next memory access
        acc_size_e  piece_size;   // encoded size of that access
    } piece_plan_t;

    localparam int MAX_LEN = 4;

    function automatic acc_size_e size_of(input logic [2:0] nbytes);
        case (nbytes)
            3'd4:    return SZ_WORD;
            3'd2:    return SZ_HALF;
            default: return SZ_BYTE;
        endcase
    endfunction

    function automatic logic [31:0] byte_mask(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd3:    return 32'h00FF_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/lin_split_plan.sv
module lin_split_plan
    import lin_split_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  logic [2:0]         rem_len,
    input  logic [PAGE_BITS:0] page_left,
    input  logic [2:0]         piece_left,
    output piece_plan_t        plan
);
    localparam int PW = PAGE_BITS + 1;

    always_comb begin
        // chunk = smaller of remaining length and page budget
        if ({{(PW-3){1'b0}}, rem_len} <= page_left)
            plan.chunk_len = rem_len;
        else
            plan.chunk_len = page_left[2:0];
        // a three-byte chunk starts with a single byte
        if (piece_left == 3'd3)
            plan.piece_bytes = 3'd1;
        else
            plan.piece_bytes = piece_left;
        plan.piece_size = size_of(plan.piece_bytes);
    end

endmodule

// File: rtl/lin_split_data.sv
module lin_split_data
    import lin_split_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] wdata_in,
    input  logic        step,
    input  logic [2:0]  nbytes,
    input  logic [31:0] rdata_in,
    output logic [31:0] acc_out,
    output logic [31:0] wbuf_out
);
    logic [31:0] acc;
    logic [31:0] wbuf;
    logic [5:0]  bit_pos;
    logic [5:0]  step_bits;

    assign step_bits = {nbytes, 3'b000};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            wbuf    <= '0;
            bit_pos <= '0;
        end else if (load) begin
            acc     <= '0;
            wbuf    <= wdata_in;
            bit_pos <= '0;
        end else if (step) begin
            acc     <= acc | ((rdata_in & byte_mask(nbytes)) << bit_pos);
            wbuf    <= wbuf >> step_bits;
            bit_pos <= bit_pos + step_bits;
        end
    end

    assign acc_out  = acc;
    assign wbuf_out = wbuf;

    // R5: no piece may reach beyond the 32-bit result
    assert_word_fill_R5: assert property (@(posedge clk) disable iff (rst)
        step |-> ({1'b0, bit_pos} + {1'b0, step_bits}) <= 7'd32);

endmodule

// File: rtl/lin_split.sv
module lin_split
    import lin_split_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_len,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [31:0]       rsp_rdata,
    output logic [ADDR_W-1:0] rsp_fault_addr,
    output logic              xl_req_valid,
    input  logic              xl_req_ready,
    output logic [ADDR_W-1:0] xl_req_addr,
    output logic              xl_req_write,
    input  logic              xl_rsp_valid,
    input  logic [ADDR_W-1:0] xl_rsp_paddr,
    input  logic              xl_rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [1:0]        mem_req_size,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_rdata
);
    localparam int PW = PAGE_BITS + 1;
    localparam logic [PW-1:0] PAGE_FULL = {1'b1, {PAGE_BITS{1'b0}}};

    split_state_e      state;
    rsp_status_e       status;
    logic [ADDR_W-1:0] lin_addr;
    logic [ADDR_W-1:0] phys_addr;
    logic [2:0]        rem_len;
    logic [PW-1:0]     page_left;
    logic [2:0]        piece_left;
    logic              is_write;

    piece_plan_t       plan;
    logic [31:0]       acc;
    logic [31:0]       wbuf;
    logic              accept;
    logic              bad_len;
    logic              piece_done;
    logic [PW-1:0]     page_dec;

    lin_split_plan #(.PAGE_BITS(PAGE_BITS)) u_plan (
        .rem_len    (rem_len),
        .page_left  (page_left),
        .piece_left (piece_left),
        .plan       (plan)
    );

    assign accept     = (state == ST_IDLE) && req_valid;
    assign bad_len    = (req_len == 3'd0) || (req_len > 3'(MAX_LEN));
    assign piece_done = (state == ST_MWAIT) && mem_rsp_valid;
    assign page_dec   = page_left - {{(PW-3){1'b0}}, plan.piece_bytes};

    lin_split_data u_data (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .wdata_in (req_wdata),
        .step     (piece_done),
        .nbytes   (plan.piece_bytes),
        .rdata_in (mem_rsp_rdata),
        .acc_out  (acc),
        .wbuf_out (wbuf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            status     <= RSP_OK;
            lin_addr   <= '0;
            phys_addr  <= '0;
            rem_len    <= '0;
            page_left  <= PAGE_FULL;
            piece_left <= '0;
            is_write   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    lin_addr  <= req_addr;
                    is_write  <= req_write;
                    rem_len   <= req_len;
                    page_left <= PAGE_FULL - {1'b0, req_addr[PAGE_BITS-1:0]};
                    if (bad_len) begin
                        status <= RSP_BADLEN;
                        state  <= ST_RESP;
                    end else begin
                        status <= RSP_OK;
                        state  <= ST_XREQ;
                    end
                end
                ST_XREQ: if (xl_req_ready) state <= ST_XWAIT;
                ST_XWAIT: if (xl_rsp_valid) begin
                    if (xl_rsp_fault) begin
                        status <= RSP_FAULT;
                        state  <= ST_RESP;
                    end else begin
                        phys_addr  <= xl_rsp_paddr;
                        piece_left <= plan.chunk_len;
                        state      <= ST_MREQ;
                    end
                end
                ST_MREQ: if (mem_req_ready) state <= ST_MWAIT;
                ST_MWAIT: if (mem_rsp_valid) begin
                    lin_addr   <= lin_addr + {{(ADDR_W-3){1'b0}}, plan.piece_bytes};
                    phys_addr  <= phys_addr + {{(ADDR_W-3){1'b0}}, plan.piece_bytes};
                    rem_len    <= rem_len - plan.piece_bytes;
                    piece_left <= piece_left - plan.piece_bytes;
                    page_left  <= (page_dec == '0) ? PAGE_FULL : page_dec;
                    if (piece_left != plan.piece_bytes)
                        state <= ST_MREQ;
                    else if (rem_len == plan.piece_bytes)
                        state <= ST_RESP;
                    else
                        state <= ST_XREQ;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready      = (state == ST_IDLE);
    assign rsp_valid      = (state == ST_RESP);
    assign rsp_status     = status;
    assign rsp_rdata      = acc;
    assign rsp_fault_addr = lin_addr;
    assign xl_req_valid   = (state == ST_XREQ);
    assign xl_req_addr    = lin_addr;
    assign xl_req_write   = is_write;
    assign mem_req_valid  = (state == ST_MREQ);
    assign mem_req_write  = is_write;
    assign mem_req_addr   = phys_addr;
    assign mem_req_size   = plan.piece_size;
    assign mem_req_wdata  = wbuf & byte_mask(plan.piece_bytes);

    // R2: illegal length answered in the next cycle
    assert_badlen_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && bad_len) |=> (rsp_valid && rsp_status == RSP_BADLEN));

    // R3: every chunk holds between one and four bytes
    assert_chunk_range_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XWAIT && xl_rsp_valid && !xl_rsp_fault)
            |-> (plan.chunk_len != 3'd0 && plan.chunk_len <= 3'(MAX_LEN)));

    // R3: no memory access runs past the end of its page
    assert_in_page_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (({1'b0, lin_addr[PAGE_BITS-1:0]}
                            + {{(PW-3){1'b0}}, plan.piece_bytes}) <= PAGE_FULL));

    // R7: a translation fault ends the operation at once
    assert_fault_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (xl_rsp_valid && xl_rsp_fault && state == ST_XWAIT)
            |=> (rsp_valid && rsp_status == RSP_FAULT && !mem_req_valid));

    // R8: memory request held stable until taken
    assert_mem_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready)
            |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)));

    // R8: response is a single-cycle pulse
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/lin_split_test.sv
module lin_split_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PHYS_XOR   = 32'h0040_0000;
    localparam logic [19:0] FAULT_PAGE = 20'h00007;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_addr;
    logic [2:0]  req_len;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata, rsp_fault_addr;
    logic        xl_req_valid, xl_req_ready, xl_req_write;
    logic [31:0] xl_req_addr;
    logic        xl_rsp_valid, xl_rsp_fault;
    logic [31:0] xl_rsp_paddr;
    logic        mem_req_valid, mem_req_ready, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_split uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .rsp_fault_addr(rsp_fault_addr),
        .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready),
        .xl_req_addr(xl_req_addr), .xl_req_write(xl_req_write),
        .xl_rsp_valid(xl_rsp_valid), .xl_rsp_paddr(xl_rsp_paddr),
        .xl_rsp_fault(xl_rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // bench-side logs written by the responder models
    int          xl_n = 0, pc_n = 0, wb_n = 0;
    logic [31:0] xl_log [0:1023];
    logic [31:0] pc_addr[0:1023];
    logic [1:0]  pc_size[0:1023];
    logic [31:0] wb_addr[0:1023];
    logic [7:0]  wb_data[0:1023];
    logic [3:0]  rdy_cnt = '0;

    function automatic logic [31:0] phys(input logic [31:0] a);
        return a ^ PHYS_XOR;
    endfunction

    function automatic logic [7:0] fbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic int size_bytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : ((s == 2'd1) ? 2 : 4);
    endfunction

    function automatic logic [1:0] size_code(input int c);
        return (c == 4) ? 2'd2 : ((c == 2) ? 2'd1 : 2'd0);
    endfunction

    // translation model: one-cycle latency
    always @(posedge clk) begin
        xl_rsp_valid <= 1'b0;
        if (!rst && xl_req_valid && xl_req_ready) begin
            xl_rsp_valid <= 1'b1;
            xl_rsp_paddr <= phys(xl_req_addr);
            xl_rsp_fault <= (xl_req_addr[31:12] == FAULT_PAGE);
            xl_log[xl_n[9:0]] = xl_req_addr;
            xl_n = xl_n + 1;
        end
    end

    // memory model: intermittent ready, upper read bytes filled with junk
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        rdy_cnt       <= rdy_cnt + 4'd1;
        mem_req_ready <= (rdy_cnt[1:0] != 2'b11);
        if (!rst && mem_req_valid && mem_req_ready) begin
            logic [31:0] rd;
            int nb;
            nb = size_bytes(mem_req_size);
            rd = 32'hEEEE_EEEE;
            for (int k = 0; k < nb; k++)
                rd[8*k +: 8] = fbyte(mem_req_addr + 32'(k));
            mem_rsp_valid <= 1'b1;
            mem_rsp_rdata <= rd;
            pc_addr[pc_n[9:0]] = mem_req_addr;
            pc_size[pc_n[9:0]] = mem_req_size;
            pc_n = pc_n + 1;
            if (mem_req_write) begin
                for (int k = 0; k < nb; k++) begin
                    wb_addr[wb_n[9:0]] = mem_req_addr + 32'(k);
                    wb_data[wb_n[9:0]] = mem_req_wdata[8*k +: 8];
                    wb_n = wb_n + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // operation results
    int          xb, pb, wbb, lat;
    bit          busy_ok;
    logic [1:0]  o_st;
    logic [31:0] o_rd, o_fa;

    task automatic run_op(input bit wr, input logic [31:0] a, input logic [2:0] len,
                          input logic [31:0] wd);
        int guard;
        xb = xl_n; pb = pc_n; wbb = wb_n; busy_ok = 1; lat = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        guard = 0;
        while (!rsp_valid && guard < 500) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            lat++;
            guard++;
        end
        if (!rsp_valid) chk(0, "R8", "response timeout", 32'(guard), 32'd0);
        o_st = rsp_status; o_rd = rsp_rdata; o_fa = rsp_fault_addr;
        @(negedge clk);
    endtask

    task automatic verify_good(input bit wr, input logic [31:0] a, input int len,
                               input logic [31:0] wd);
        int off, c1, c2, p, pos;
        logic [31:0] exp_rd;
        int ch[2];
        off = int'(a[11:0]);
        c1  = (len < 4096 - off) ? len : 4096 - off;
        c2  = len - c1;
        chk(o_st == 2'd0, "R3", "status", 32'(o_st), 32'd0);
        chk(xl_n - xb == ((c2 != 0) ? 2 : 1), "R3", "translation count",
            32'(xl_n - xb), 32'((c2 != 0) ? 2 : 1));
        chk(xl_log[xb[9:0]] == a, "R3", "first translation address", xl_log[xb[9:0]], a);
        if (c2 != 0)
            chk(xl_log[(xb+1) & 1023] == a + 32'(c1), "R3", "second translation address",
                xl_log[(xb+1) & 1023], a + 32'(c1));
        ch[0] = c1; ch[1] = c2;
        p = 0; pos = 0;
        for (int j = 0; j < 2; j++) begin
            if (ch[j] == 3) begin
                chk(pc_size[(pb+p) & 1023] == 2'd0, "R4", "3-byte chunk lead size",
                    32'(pc_size[(pb+p) & 1023]), 32'd0);
                chk(pc_addr[(pb+p) & 1023] == phys(a + 32'(pos)), "R4", "3-byte lead addr",
                    pc_addr[(pb+p) & 1023], phys(a + 32'(pos)));
                chk(pc_size[(pb+p+1) & 1023] == 2'd1, "R4", "3-byte tail size",
                    32'(pc_size[(pb+p+1) & 1023]), 32'd1);
                chk(pc_addr[(pb+p+1) & 1023] == phys(a + 32'(pos + 1)), "R4", "3-byte tail addr",
                    pc_addr[(pb+p+1) & 1023], phys(a + 32'(pos + 1)));
                p += 2;
            end else if (ch[j] != 0) begin
                chk(pc_size[(pb+p) & 1023] == size_code(ch[j]), "R4", "piece size",
                    32'(pc_size[(pb+p) & 1023]), 32'(size_code(ch[j])));
                chk(pc_addr[(pb+p) & 1023] == phys(a + 32'(pos)), "R4", "piece addr",
                    pc_addr[(pb+p) & 1023], phys(a + 32'(pos)));
                p += 1;
            end
            pos += ch[j];
        end
        chk(pc_n - pb == p, "R4", "piece count", 32'(pc_n - pb), 32'(p));
        if (!wr) begin
            exp_rd = '0;
            for (int i = 0; i < len; i++) exp_rd[8*i +: 8] = fbyte(phys(a + 32'(i)));
            chk(o_rd == exp_rd, "R5", "read data", o_rd, exp_rd);
            chk(wb_n == wbb, "R5", "no bytes written on read", 32'(wb_n - wbb), 32'd0);
        end else begin
            chk(wb_n - wbb == len, "R6", "bytes written", 32'(wb_n - wbb), 32'(len));
            for (int i = 0; i < len; i++) begin
                chk(wb_addr[(wbb+i) & 1023] == phys(a + 32'(i)), "R6", "write byte addr",
                    wb_addr[(wbb+i) & 1023], phys(a + 32'(i)));
                chk(wb_data[(wbb+i) & 1023] == wd[8*i +: 8], "R6", "write byte data",
                    32'(wb_data[(wbb+i) & 1023]), 32'(wd[8*i +: 8]));
            end
        end
        chk(busy_ok, "R8", "req_ready low while busy", 32'(busy_ok), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            chk(0, "R8", "watchdog expired", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] wd;
        int op;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_len = '0; req_wdata = '0; xl_req_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk(xl_req_valid == 1'b0, "R1", "xl_req_valid after reset", 32'(xl_req_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);

        // R2 illegal lengths
        for (int L = 5; L <= 8; L++) begin
            run_op(1'b1, 32'h0001_2FFE, 3'(L), 32'h1122_3344);
            chk(o_st == 2'd1, "R2", "bad-length status", 32'(o_st), 32'd1);
            chk(lat == 1, "R2", "bad-length latency", 32'(lat), 32'd1);
            chk(xl_n == xb && pc_n == pb, "R2", "no traffic on bad length",
                32'(xl_n - xb + pc_n - pb), 32'd0);
        end

        // R3..R6 sweep near page boundaries
        op = 0;
        for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 12; k++) begin
                for (int L = 1; L <= 4; L++) begin
                    logic [31:0] a;
                    a  = 32'h0001_2000 + ((k < 4) ? 32'(k) : 32'(32'hFF8 + k - 4));
                    wd = 32'h9A7B_3C10 + 32'(op) * 32'h0107_0305;
                    run_op(w[0], a, 3'(L), wd);
                    verify_good(w[0], a, L, wd);
                    op++;
                end
            end
        end

        // R7 fault on second chunk of a write: first two bytes stay written
        run_op(1'b1, 32'h0000_6FFE, 3'd4, 32'hA1B2_C3D4);
        chk(o_st == 2'd2, "R7", "fault status", 32'(o_st), 32'd2);
        chk(o_fa == 32'h0000_7000, "R7", "fault address", o_fa, 32'h0000_7000);
        chk(wb_n - wbb == 2, "R7", "bytes kept before fault", 32'(wb_n - wbb), 32'd2);
        chk(wb_data[wbb[9:0]] == 8'hD4 && wb_addr[wbb[9:0]] == phys(32'h6FFE), "R7",
            "kept byte 0", {24'd0, wb_data[wbb[9:0]]}, 32'h0000_00D4);
        chk(wb_data[(wbb+1) & 1023] == 8'hC3, "R7", "kept byte 1",
            32'(wb_data[(wbb+1) & 1023]), 32'h0000_00C3);
        chk(pc_n - pb == 1, "R7", "no access after fault", 32'(pc_n - pb), 32'd1);

        // R7 fault on first chunk of a read
        run_op(1'b0, 32'h0000_7FFD, 3'd2, 32'h0);
        chk(o_st == 2'd2, "R7", "first-chunk fault status", 32'(o_st), 32'd2);
        chk(o_fa == 32'h0000_7FFD, "R7", "first-chunk fault address", o_fa, 32'h0000_7FFD);
        chk(pc_n == pb, "R7", "no memory access on first fault", 32'(pc_n - pb), 32'd0);

        // recovery after fault
        run_op(1'b0, 32'h0001_3FFF, 3'd3, 32'h0);
        verify_good(1'b0, 32'h0001_3FFF, 3, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule